// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates among a set of level or edge driven peripheral request lines and one non-maskable line, and hands the most urgent of them to a processor core. Every source holds its own two-bit life cycle (inactive, pending, active, pending-and-active), an enable flag and a 4-bit urgency value. A small command port lets software enable, disable, force-pend, clear-pend or re-rank any source. The core sees a request strobe with a vector number, accepts it with an acknowledge pulse, and later signals the end of that handler with a return pulse.

The 4-bit urgency splits into an upper group field (GROUP_BITS wide) and a lower sub field. Among the candidates, the lowest full value wins, and the lower index wins a tie. Only the group field decides whether a new winner may interrupt a running handler, and it must be strictly more urgent. The running handlers are kept on an internal stack, one entry deeper than the number of distinct groups. When a handler returns and another candidate is eligible against the remaining stack, the controller offers it on the very next edge with no idle cycle in between.

The sequencer has three states. IDLE means nothing is running and nothing is offered. RUN means handlers are on the stack and nothing is offered. OFFER means req_o is high. The transitions are these. IDLE goes to OFFER when a winner exists. RUN goes to OFFER on a preempting winner, or on a return that leaves an eligible winner (the tail-chain). RUN goes to IDLE on a return that empties the stack with no winner. OFFER goes to RUN on acknowledge. OFFER re-evaluates every cycle, and falls back to IDLE or RUN when no eligible winner remains.

Top module: `pvic_ctrl`

## Requirements
- R1: After reset, no source is pending, active or enabled, and req_o is low.
- R2: While req_o is high, vec_o names the enabled, pending, not-active source with the lowest urgency value. The lower index wins between equal values, and the offer tracks a better candidate that appears while offering.
- R3: A source becomes pending when its input is sampled high while it is not active. It also becomes pending on a sampled rising edge of its input, even while active, which gives pending-and-active.
- R4: The cfg_op codes are 0 enable, 1 disable, 2 set-pending, 3 clear-pending and 4 write urgency (cfg_val). Set-pending makes the source pending regardless of its input.
- R5: An acknowledge in a cycle with req_o high moves the offered source from pending to active. It pushes that source on the handler stack, and req_o is low after that edge.
- R6: A return (eoi_i) retires the top handler. That source becomes pending again if its input is high at that edge, and inactive otherwise.
- R7: A clear-pending command has no effect while the source input is high. With the input low, it returns the source to inactive.
- R8: A disabled source still becomes pending but is never offered. Once enabled, a pending source is offered.
- R9: While a handler runs, a winner is offered only if its group field (urgency bits [3:2] by default) is numerically lower than the running handler's group. Equal group with a better sub field waits.
- R10: On a return that leaves an eligible winner against the remaining stack, req_o is high right after that return edge (tail-chain). The stack never exceeds 2^GROUP_BITS+1 entries.
- R11: A rising edge of nmi_i makes the non-maskable source pending. It is offered as vector NUM_SRC ahead of every other source and preempts any running handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_SRC | Peripheral request lines, synchronous |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| cfg_we | input | 1 | Command strobe |
| cfg_op | input | 3 | Command code (see R4) |
| cfg_idx | input | $clog2(NUM_SRC) | Target source index |
| cfg_val | input | PRIO_W | Urgency value for command 4 |
| ack_i | input | 1 | Core accepts the offered vector |
| eoi_i | input | 1 | Core returns from the current handler |
| req_o | output | 1 | Offer to the core |
| vec_o | output | $clog2(NUM_SRC+1) | Offered vector, NUM_SRC for non-maskable |
| pend_o | output | NUM_SRC | Pending flag per source |
| act_o | output | NUM_SRC | Active flag per source |

## Verification
Each result has a fixed due cycle. A pending flag appears after the edge that samples the input or command. req_o and vec_o follow one edge later, because the winner is registered into the offer. Acknowledge and return effects on pend_o, act_o and req_o appear right after the edge that samples the pulse, and a tail-chained offer is due after that same return edge. The driver queues every expectation just after the edge that makes it due, and the monitor compares it on the following falling edge, so each check lands exactly in its due cycle.

// File: rtl/pvic_pkg.sv
`timescale 1ns/1ps
package pvic_pkg;
    typedef enum logic [2:0] {
        OP_EN   = 3'd0,
        OP_DIS  = 3'd1,
        OP_SETP = 3'd2,
        OP_CLRP = 3'd3,
        OP_PRIO = 3'd4
    } cfg_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_OFFER = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/pvic_src_cell.sv
`timescale 1ns/1ps
module pvic_src_cell #(
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_i,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              set_pend,
    input  logic              clr_pend,
    input  logic              prio_we,
    input  logic [PRIO_W-1:0] prio_val,
    input  logic              take,
    input  logic              ret,
    output logic              en_o,
    output logic [PRIO_W-1:0] prio_o,
    output logic              pend_o,
    output logic              act_o
);
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            en_o   <= 1'b0;
            prio_o <= '0;
            pend_o <= 1'b0;
            act_o  <= 1'b0;
        end else begin
            irq_q <= irq_i;
            if (en_set)       en_o <= 1'b1;
            else if (en_clr)  en_o <= 1'b0;
            if (prio_we)      prio_o <= prio_val;
            if (take) begin
                pend_o <= 1'b0;
                act_o  <= 1'b1;
            end else if (ret) begin
                act_o  <= 1'b0;
                pend_o <= pend_o | irq_i | set_pend;
            end else if (set_pend || (irq_i && !act_o) || (irq_i && !irq_q)) begin
                pend_o <= 1'b1;
            end else if (clr_pend && !irq_i) begin
                pend_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pvic_arbiter.sv
`timescale 1ns/1ps
module pvic_arbiter #(
    parameter int NUM_SRC    = 35,
    parameter int PRIO_W     = 4,
    parameter int GROUP_BITS = 2,
    localparam int VEC_W     = $clog2(NUM_SRC + 1),
    localparam int KEY_W     = GROUP_BITS + 1
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC-1:0]        act,
    input  logic [NUM_SRC-1:0]        en,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic                      nmi_pend,
    input  logic                      nmi_act,
    output logic                      win_valid,
    output logic [VEC_W-1:0]          win_vec,
    output logic [KEY_W-1:0]          win_key
);
    logic [PRIO_W-1:0] cur;
    logic [PRIO_W-1:0] best;

    always_comb begin
        win_valid = 1'b0;
        win_vec   = '0;
        best      = '1;
        cur       = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            cur = prio_flat[i*PRIO_W +: PRIO_W];
            if (pend[i] && en[i] && !act[i] && (!win_valid || cur < best)) begin
                win_valid = 1'b1;
                best      = cur;
                win_vec   = VEC_W'(i);
            end
        end
        win_key = {1'b1, best[PRIO_W-1 -: GROUP_BITS]};
        if (nmi_pend && !nmi_act) begin
            win_valid = 1'b1;
            win_vec   = VEC_W'(NUM_SRC);
            win_key   = '0;
        end
    end
endmodule

// File: rtl/pvic_ctrl.sv
`timescale 1ns/1ps
module pvic_ctrl
    import pvic_pkg::*;
#(
    parameter int NUM_SRC    = 35,
    parameter int PRIO_W     = 4,
    parameter int GROUP_BITS = 2,
    localparam int IDX_W     = $clog2(NUM_SRC),
    localparam int VEC_W     = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic               nmi_i,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_op,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [PRIO_W-1:0]  cfg_val,
    input  logic               ack_i,
    input  logic               eoi_i,
    output logic               req_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] act_o
);
    localparam int KEY_W = GROUP_BITS + 1;
    localparam int DEPTH = (1 << GROUP_BITS) + 1;
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_SRC);

    ctl_state_e state, nxt;
    cfg_op_e    op;

    logic [VEC_W-1:0] vec_q;
    logic [KEY_W-1:0] key_q;
    logic [VEC_W-1:0] stk_vec [DEPTH];
    logic [KEY_W-1:0] stk_key [DEPTH];
    logic [SP_W-1:0]  sp, post_sp;

    logic [NUM_SRC-1:0]        en_v;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic nmi_q, nmi_pend, nmi_act;

    logic             win_valid;
    logic [VEC_W-1:0] win_vec;
    logic [KEY_W-1:0] win_key;
    logic             push, pop, preempt_ok;
    logic [VEC_W-1:0] top_vec;
    logic [KEY_W-1:0] post_key;

    assign op = cfg_op_e'(cfg_op);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        logic hit;
        assign hit = cfg_we && (cfg_idx == IDX_W'(i));
        pvic_src_cell #(.PRIO_W(PRIO_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_i    (irq_i[i]),
            .en_set   (hit && (op == OP_EN)),
            .en_clr   (hit && (op == OP_DIS)),
            .set_pend (hit && (op == OP_SETP)),
            .clr_pend (hit && (op == OP_CLRP)),
            .prio_we  (hit && (op == OP_PRIO)),
            .prio_val (cfg_val),
            .take     (push && (vec_q == VEC_W'(i))),
            .ret      (pop && (top_vec == VEC_W'(i))),
            .en_o     (en_v[i]),
            .prio_o   (prio_flat[i*PRIO_W +: PRIO_W]),
            .pend_o   (pend_o[i]),
            .act_o    (act_o[i])
        );
    end

    pvic_arbiter #(
        .NUM_SRC    (NUM_SRC),
        .PRIO_W     (PRIO_W),
        .GROUP_BITS (GROUP_BITS)
    ) u_arb (
        .pend      (pend_o),
        .act       (act_o),
        .en        (en_v),
        .prio_flat (prio_flat),
        .nmi_pend  (nmi_pend),
        .nmi_act   (nmi_act),
        .win_valid (win_valid),
        .win_vec   (win_vec),
        .win_key   (win_key)
    );

    // Stack view after this cycle's return, used for the preemption test.
    always_comb begin
        push       = (state == ST_OFFER) && ack_i;
        pop        = eoi_i && (sp != '0) && !push;
        top_vec    = (sp != '0) ? stk_vec[sp - SP_W'(1)] : '0;
        post_sp    = pop ? (sp - SP_W'(1)) : sp;
        post_key   = (post_sp != '0) ? stk_key[post_sp - SP_W'(1)] : '1;
        preempt_ok = win_valid && ((post_sp == '0) || (win_key < post_key));
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (preempt_ok) nxt = ST_OFFER;
            ST_RUN: begin
                if (preempt_ok)          nxt = ST_OFFER;
                else if (post_sp == '0)  nxt = ST_IDLE;
            end
            ST_OFFER: begin
                if (push)                nxt = ST_RUN;
                else if (!preempt_ok)    nxt = (post_sp == '0) ? ST_IDLE : ST_RUN;
            end
            default:                     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q    <= '0;
            key_q    <= '0;
            sp       <= '0;
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
            nmi_act  <= 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                stk_vec[j] <= '0;
                stk_key[j] <= '0;
            end
        end else begin
            if (preempt_ok && !push) begin
                vec_q <= win_vec;
                key_q <= win_key;
            end
            if (push) begin
                stk_vec[sp] <= vec_q;
                stk_key[sp] <= key_q;
                sp          <= sp + SP_W'(1);
            end else if (pop) begin
                sp <= sp - SP_W'(1);
            end
            nmi_q <= nmi_i;
            if (push && (vec_q == NMI_VEC)) begin
                nmi_pend <= 1'b0;
                nmi_act  <= 1'b1;
            end else begin
                if (pop && (top_vec == NMI_VEC)) nmi_act  <= 1'b0;
                if (nmi_i && !nmi_q)             nmi_pend <= 1'b1;
            end
        end
    end

    always_comb begin
        req_o = (state == ST_OFFER);
        vec_o = vec_q;
    end
endmodule

// File: rtl/pvic_chk.sv
`timescale 1ns/1ps
module pvic_chk #(
    parameter int NUM_SRC    = 35,
    parameter int GROUP_BITS = 2,
    localparam int IDX_W     = $clog2(NUM_SRC),
    localparam int VEC_W     = $clog2(NUM_SRC + 1),
    localparam int DEPTH     = (1 << GROUP_BITS) + 1,
    localparam int SP_W      = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_i,
    input logic               cfg_we,
    input logic [2:0]         cfg_op,
    input logic [IDX_W-1:0]   cfg_idx,
    input logic               ack_i,
    input logic               eoi_i,
    input logic               req_o,
    input logic [VEC_W-1:0]   vec_o,
    input logic [NUM_SRC-1:0] pend_o,
    input logic [NUM_SRC-1:0] act_o,
    input logic [SP_W-1:0]    sp
);
    AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && ack_i && (vec_o < VEC_W'(NUM_SRC)) |=> act_o[$past(vec_o)]); // R5

    AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SP_W'(DEPTH)); // R10

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        logic taken;
        assign taken = req_o && ack_i && (vec_o == VEC_W'(k));

        AST_EDGE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_i[k]) && !taken |=> pend_o[k]); // R3

        AST_RET_REPEND: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(act_o[k]) && $past(irq_i[k]) |-> pend_o[k]); // R6

        AST_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_we && (cfg_op == 3'd3) && (cfg_idx == IDX_W'(k)) && irq_i[k]
            && pend_o[k] && !taken |=> pend_o[k]); // R7
    end
endmodule

bind pvic_ctrl pvic_chk #(
    .NUM_SRC    (NUM_SRC),
    .GROUP_BITS (GROUP_BITS)
) u_pvic_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_i   (irq_i),
    .cfg_we  (cfg_we),
    .cfg_op  (cfg_op),
    .cfg_idx (cfg_idx),
    .ack_i   (ack_i),
    .eoi_i   (eoi_i),
    .req_o   (req_o),
    .vec_o   (vec_o),
    .pend_o  (pend_o),
    .act_o   (act_o),
    .sp      (sp)
);

// File: tb/test_pvic_ctrl.sv
`timescale 1ns/1ps
module test_pvic_ctrl;
    localparam int NS    = 35;
    localparam int NMI_V = 35;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq = '0;
    logic          nmi = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_op = '0;
    logic [5:0]    cfg_idx = '0;
    logic [3:0]    cfg_val = '0;
    logic          ack = 1'b0;
    logic          eoi = 1'b0;
    logic          req;
    logic [5:0]    vec;
    logic [NS-1:0] pend, act;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        string  tag;
        int     kind;
        int     idx;
        longint exp;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    pvic_ctrl i_pvic_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .nmi_i(nmi),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_val(cfg_val),
        .ack_i(ack), .eoi_i(eoi), .req_o(req), .vec_o(vec),
        .pend_o(pend), .act_o(act)
    );

    // kinds: 0 req, 1 vec, 2 pend bit, 3 act bit, 4 pend vector, 5 act vector
    task automatic want(string tag, int kind, int idx, longint exp);
        item_t it;
        it.tag = tag; it.kind = kind; it.idx = idx; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic want_offer(string tag, int v);
        want(tag, 0, 0, 1);
        want(tag, 1, 0, longint'(v));
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(int op, int idx, int val);
        cfg_we = 1'b1; cfg_op = 3'(op); cfg_idx = 6'(idx); cfg_val = 4'(val);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1; tick(); eoi = 1'b0;
    endtask

    always @(negedge clk) begin
        item_t  e;
        longint got;
        while (sb.size() != 0) begin
            e = sb.pop_front();
            case (e.kind)
                0: got = longint'(req);
                1: got = longint'(vec);
                2: got = longint'(pend[e.idx]);
                3: got = longint'(act[e.idx]);
                4: got = longint'(pend);
                5: got = longint'(act);
                default: got = -1;
            endcase
            n_chk++;
            if (got != e.exp) begin
                n_bad++;
                $display("FAIL %s: got %0d expected %0d", e.tag, got, e.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        want("R1 req", 0, 0, 0);
        want("R1 pend", 4, 0, 0);
        want("R1 act", 5, 0, 0);
        tick();

        cfg(4, 3, 9);  cfg(0, 3, 0);
        cfg(4, 7, 8);  cfg(0, 7, 0);
        cfg(4, 10, 4); cfg(0, 10, 0);
        cfg(4, 20, 4); cfg(0, 20, 0);
        cfg(4, 21, 6); cfg(0, 21, 0);
        cfg(4, 30, 5); cfg(0, 30, 0);
        cfg(4, 5, 0);
        want("R1 idle after cfg", 0, 0, 0);

        // level pend, offer, ack, edge while active, re-pend, retire
        irq[3] = 1'b1; tick();
        want("R3 level pend", 2, 3, 1);
        tick();
        want_offer("R2 single offer", 3);
        do_ack();
        want("R5 act", 3, 3, 1); want("R5 pend cleared", 2, 3, 0); want("R5 req low", 0, 0, 0);
        irq[3] = 1'b0; tick();
        irq[3] = 1'b1; tick();
        want("R3 edge while active pend", 2, 3, 1); want("R3 edge while active act", 3, 3, 1);
        want("R3 active not offered", 0, 0, 0);
        do_eoi();
        want("R6 ret act", 3, 3, 0); want("R6 ret pend kept", 2, 3, 1);
        tick();
        want_offer("R6 reoffer", 3);
        do_ack();
        do_eoi();
        want("R6 level repend", 2, 3, 1); want("R6 repend act", 3, 3, 0);
        irq[3] = 1'b0; tick();
        want_offer("R6 offer after repend", 3);
        do_ack();
        do_eoi();
        want("R6 inactive pend", 2, 3, 0); want("R6 inactive act", 3, 3, 0);
        tick();
        want("R6 idle", 0, 0, 0);

        // disabled pending and clear-pending rules
        irq[5] = 1'b1; tick();
        want("R8 disabled pends", 2, 5, 1);
        tick();
        want("R8 disabled not offered", 0, 0, 0);
        cfg(3, 5, 0);
        want("R7 clear ignored while high", 2, 5, 1);
        irq[5] = 1'b0; tick();
        want("R7 latched after drop", 2, 5, 1);
        cfg(3, 5, 0);
        want("R7 clear with input low", 2, 5, 0);
        cfg(2, 5, 0);
        want("R4 set-pend disabled", 2, 5, 1);
        cfg(0, 5, 0);
        tick();
        want_offer("R8 served once enabled", 5);
        do_ack(); do_eoi(); tick();
        want("R8 done", 0, 0, 0); want("R8 done pend", 2, 5, 0);
        cfg(1, 5, 0);

        // ordering, tie, equal group, tail-chain
        cfg(2, 3, 0);
        want("R4 set-pend", 2, 3, 1);
        cfg(2, 10, 0);
        want("R4 set-pend 10", 2, 10, 1);
        tick();
        want_offer("R2 better value takes offer", 10);
        cfg(2, 20, 0);
        tick();
        want_offer("R2 tie lower index", 10);
        do_ack();
        want("R5 req low after ack", 0, 0, 0);
        tick();
        want("R9 equal group waits", 0, 0, 0);
        do_eoi();
        want_offer("R10 tail-chain to 20", 20);
        want("R10 retired act", 3, 10, 0);
        do_ack();
        do_eoi();
        want_offer("R10 tail-chain to 3", 3);
        do_ack(); do_eoi(); tick();
        want("R10 idle", 0, 0, 0);

        cfg(2, 21, 0);
        cfg(2, 30, 0);
        tick();
        want_offer("R2 sub field decides", 30);
        do_ack();
        do_eoi();
        want_offer("R10 tail-chain to 21", 21);
        do_ack(); do_eoi(); tick();
        want("R2 idle", 0, 0, 0);

        // nesting and non-maskable
        cfg(2, 3, 0);
        tick();
        want_offer("R9 base offer", 3);
        do_ack();
        cfg(2, 7, 0);
        tick();
        want("R9 same group no preempt", 0, 0, 0);
        cfg(2, 10, 0);
        tick();
        want_offer("R9 higher group preempts", 10);
        do_ack();
        want("R9 nested act 10", 3, 10, 1); want("R9 nested act 3", 3, 3, 1);
        nmi = 1'b1; tick();
        tick();
        want_offer("R11 nmi preempts", NMI_V);
        nmi = 1'b0;
        do_ack();
        tick();
        want("R11 nmi running", 0, 0, 0);
        do_eoi();
        want("R9 after nmi return", 0, 0, 0); want("R9 10 still active", 3, 10, 1);
        do_eoi();
        want("R9 group2 still blocked", 0, 0, 0); want("R9 10 retired", 3, 10, 0);
        do_eoi();
        want_offer("R10 tail-chain to 7", 7);
        do_ack(); do_eoi(); tick();
        want("R10 final idle", 0, 0, 0);
        want("R10 final pend", 4, 0, 0);
        want("R10 final act", 5, 0, 0);

        tick();
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule